// File: doc/BRIEF.md
# Transmit Prefill Back-off Scheduler

This block gates each outbound host transaction against the time still left in the current (micro)frame. When a requester offers an OUT or SETUP packet, the scheduler works out two figures from programmable tuning values. The first is the send-only time: a fixed per-packet overhead plus the payload length times a per-byte cost. The second is the full budget: that send-only time plus a programmable fetch allowance. Prefill into the transmit latency FIFO starts only when the full budget still fits in the frame.

While the FIFO is filling, the block re-checks the remaining frame time on every cycle. If the send-only time no longer fits, it abandons the attempt. It pulses a back-off indication, flushes the partly fetched data and bumps a saturating health counter. The packet stays pending, and the requester offers it again later. When the FIFO holds enough 32-bit words for the whole packet, the block reports the packet ready. Inbound (IN) requests skip the time check entirely. The scheduler only takes requests while host mode is set. It also clamps the programmed memory burst length to the 1..4 word range.

Top module: `tx_prefill_sched`

## Requirements
- R1: After reset `req_ready` equals `host_mode`. `fetch_en`, `fifo_flush`, `pkt_done`, `pkt_defer` and `pkt_backoff` are low, and `health_cnt` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The kind encoding is 2'b00 OUT, 2'b01 SETUP, and any other code is IN. An accepted IN request gives a one-cycle `pkt_done` after that edge, whatever the frame time, with no fetch and no change to `health_cnt`.
- R3: An accepted OUT or SETUP request is admitted when `frame_left` >= `cfg_fetch_time` + `cfg_overhead` + `req_len`*`cfg_byte_time`. In that case `fetch_en` is high from the next cycle. Otherwise the block gives a one-cycle `pkt_defer`, `fetch_en` stays low and `health_cnt` is unchanged.
- R4: While filling, `fetch_en` stays high until `fifo_level` (in 32-bit words) reaches ceil(`req_len`/4). At the edge where it does, the block gives a one-cycle `pkt_done` and `fetch_en` falls.
- R5: While filling, if `frame_left` < `cfg_overhead` + `req_len`*`cfg_byte_time` at an edge, the next cycle shows `pkt_backoff` and `fifo_flush` for one cycle and `fetch_en` low. This back-off takes priority over completion at that same edge.
- R6: Each back-off adds one to `health_cnt`, which saturates at 2^H_W-1.
- R7: `health_clr` high at an edge sets `health_cnt` to 0 and overrides a simultaneous back-off increment.
- R8: With `host_mode` low, `req_ready` is low and requests are ignored. Dropping `host_mode` during a fill ends it with a one-cycle `fifo_flush`, no `pkt_backoff` and no `health_cnt` change.
- R9: `fetch_burst` equals `cfg_burst` clamped to at most 4 words. A programmed value of 0 yields 1.
- R10: `req_ready` is low while a fill is in progress, so only one packet is in flight.
- R11: All time comparisons are unsigned and inclusive at the limit. `frame_left` equal to the full budget admits the packet, and `frame_left` equal to the send-only time during a fill causes no back-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | Scheduler enabled when high |
| req_valid | input | 1 | Packet request offered |
| req_kind | input | 2 | 00 OUT, 01 SETUP, other IN |
| req_len | input | LEN_W | Payload length in bytes |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_overhead | input | T_W | Fixed per-packet overhead time |
| cfg_byte_time | input | BT_W | Time per payload byte |
| cfg_fetch_time | input | T_W | FIFO fetch allowance |
| cfg_burst | input | BURST_W | Programmed burst length in words |
| frame_left | input | T_W | Time remaining in the current frame |
| fifo_level | input | LVL_W | Words currently held in the latency FIFO |
| fetch_en | output | 1 | Memory-to-FIFO fetch active |
| fetch_burst | output | clog2(MAX_BURST+1) | Clamped burst length |
| fifo_flush | output | 1 | Discard partial FIFO contents |
| pkt_done | output | 1 | Packet ready to send or IN passed through |
| pkt_defer | output | 1 | Packet not admitted; retry later |
| pkt_backoff | output | 1 | Fill abandoned for lack of time |
| health_clr | input | 1 | Clear the health counter |
| health_cnt | output | H_W | Saturating back-off count |

## Verification
The assertions assume the inputs carry known values once reset is released. They also assume the tuning inputs hold still within a cycle, so that the computed send-only time seen at one edge is the one the decision used. The directed stimulus holds all configuration inputs constant while a packet is in flight. It changes inputs only between clock edges, and it lowers `host_mode` during a fill only in the test that targets that case. `frame_left` is driven as a chosen value rather than a free-running counter, so the exact budget limits can be probed on both sides.

// File: rtl/txpf_pkg.sv
package txpf_pkg;

    typedef enum logic [1:0] {
        KIND_OUT   = 2'b00,
        KIND_SETUP = 2'b01,
        KIND_IN    = 2'b10,
        KIND_RSVD  = 2'b11
    } pkt_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } txpf_state_e;

endpackage

// File: rtl/txpf_time_calc.sv
module txpf_time_calc #(
    parameter int T_W    = 16,
    parameter int LEN_W  = 11,
    parameter int BT_W   = 8,
    parameter int CALC_W = 21
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [BT_W-1:0]   byte_time,
    input  logic [T_W-1:0]    overhead,
    input  logic [T_W-1:0]    fetch_time,
    output logic [CALC_W-1:0] ts,
    output logic [CALC_W-1:0] tp,
    output logic [LEN_W-2:0]  words
);

    logic [CALC_W-1:0] payload;

    always_comb begin
        payload = CALC_W'(len) * CALC_W'(byte_time);
        ts      = payload + CALC_W'(overhead);
        tp      = ts + CALC_W'(fetch_time);
        words   = (LEN_W-1)'(len >> 2) + (LEN_W-1)'(|len[1:0]);
    end

endmodule

// File: rtl/txpf_burst_clamp.sv
module txpf_burst_clamp #(
    parameter int BURST_W   = 8,
    parameter int MAX_BURST = 4,
    localparam int OUT_W    = $clog2(MAX_BURST + 1)
) (
    input  logic [BURST_W-1:0] cfg_burst,
    output logic [OUT_W-1:0]   burst
);

    always_comb begin
        if (cfg_burst == '0) begin
            burst = OUT_W'(1);
        end else if (cfg_burst > BURST_W'(MAX_BURST)) begin
            burst = OUT_W'(MAX_BURST);
        end else begin
            burst = OUT_W'(cfg_burst);
        end
    end

endmodule

// File: rtl/txpf_health_ctr.sv
module txpf_health_ctr #(
    parameter int H_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    input  logic           clr,
    output logic [H_W-1:0] cnt
);

    localparam logic [H_W-1:0] CNT_MAX = '1;

    logic [H_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tx_prefill_sched.sv
module tx_prefill_sched
    import txpf_pkg::*;
#(
    parameter int T_W       = 16,
    parameter int LEN_W     = 11,
    parameter int BT_W      = 8,
    parameter int LVL_W     = 10,
    parameter int BURST_W   = 8,
    parameter int MAX_BURST = 4,
    parameter int H_W       = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             host_mode,
    input  logic                             req_valid,
    input  logic [1:0]                       req_kind,
    input  logic [LEN_W-1:0]                 req_len,
    output logic                             req_ready,
    input  logic [T_W-1:0]                   cfg_overhead,
    input  logic [BT_W-1:0]                  cfg_byte_time,
    input  logic [T_W-1:0]                   cfg_fetch_time,
    input  logic [BURST_W-1:0]               cfg_burst,
    input  logic [T_W-1:0]                   frame_left,
    input  logic [LVL_W-1:0]                 fifo_level,
    output logic                             fetch_en,
    output logic [$clog2(MAX_BURST+1)-1:0]   fetch_burst,
    output logic                             fifo_flush,
    output logic                             pkt_done,
    output logic                             pkt_defer,
    output logic                             pkt_backoff,
    input  logic                             health_clr,
    output logic [H_W-1:0]                   health_cnt
);

    localparam int PROD_W = LEN_W + BT_W;
    localparam int CALC_W = ((T_W > PROD_W) ? T_W : PROD_W) + 2;
    localparam int CMP_W  = (LVL_W > LEN_W) ? LVL_W : LEN_W;

    typedef struct packed {
        txpf_state_e      state;
        logic [LEN_W-1:0] len;
        logic             done;
        logic             defer;
        logic             backoff;
        logic             flush;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LEN_W-1:0]  len_sel;
    logic [CALC_W-1:0] pkt_ts;
    logic [CALC_W-1:0] pkt_tp;
    logic [LEN_W-2:0]  pkt_words;
    logic [CALC_W-1:0] left_ext;
    logic              accept;
    logic              is_tx;
    logic              fill_full;
    logic              health_inc;

    // One calculator serves admission (incoming length) and fill (held length)
    assign len_sel = (ctl_q.state == ST_IDLE) ? req_len : ctl_q.len;

    txpf_time_calc #(
        .T_W    (T_W),
        .LEN_W  (LEN_W),
        .BT_W   (BT_W),
        .CALC_W (CALC_W)
    ) i_calc (
        .len        (len_sel),
        .byte_time  (cfg_byte_time),
        .overhead   (cfg_overhead),
        .fetch_time (cfg_fetch_time),
        .ts         (pkt_ts),
        .tp         (pkt_tp),
        .words      (pkt_words)
    );

    txpf_burst_clamp #(
        .BURST_W   (BURST_W),
        .MAX_BURST (MAX_BURST)
    ) i_clamp (
        .cfg_burst (cfg_burst),
        .burst     (fetch_burst)
    );

    txpf_health_ctr #(
        .H_W (H_W)
    ) i_health (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (health_inc),
        .clr   (health_clr),
        .cnt   (health_cnt)
    );

    assign req_ready = host_mode && (ctl_q.state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign is_tx     = (req_kind == KIND_OUT) || (req_kind == KIND_SETUP);
    assign left_ext  = CALC_W'(frame_left);
    assign fill_full = CMP_W'(fifo_level) >= CMP_W'(pkt_words);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.defer   = 1'b0;
        ctl_d.backoff = 1'b0;
        ctl_d.flush   = 1'b0;
        health_inc    = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (!is_tx) begin
                        ctl_d.done = 1'b1;
                    end else if (left_ext >= pkt_tp) begin
                        ctl_d.state = ST_FILL;
                        ctl_d.len   = req_len;
                    end else begin
                        ctl_d.defer = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (!host_mode) begin
                    ctl_d.flush = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else if (left_ext < pkt_ts) begin
                    ctl_d.backoff = 1'b1;
                    ctl_d.flush   = 1'b1;
                    health_inc    = 1'b1;
                    ctl_d.state   = ST_IDLE;
                end else if (fill_full) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fetch_en    = (ctl_q.state == ST_FILL);
    assign fifo_flush  = ctl_q.flush;
    assign pkt_done    = ctl_q.done;
    assign pkt_defer   = ctl_q.defer;
    assign pkt_backoff = ctl_q.backoff;

endmodule

// File: rtl/txpf_sched_chk.sv
module txpf_sched_chk #(
    parameter int T_W    = 16,
    parameter int H_W    = 8,
    parameter int CALC_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_mode,
    input logic              req_ready,
    input logic [T_W-1:0]    frame_left,
    input logic [CALC_W-1:0] pkt_ts,
    input logic              health_clr,
    input logic [H_W-1:0]    health_cnt,
    input logic              fetch_en,
    input logic              fifo_flush,
    input logic              pkt_done,
    input logic              pkt_defer,
    input logic              pkt_backoff
);

    localparam logic [H_W-1:0] CNT_MAX = '1;

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_done, pkt_defer, pkt_backoff}));

    p_backoff_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_backoff |-> (fifo_flush && !fetch_en));

    p_backoff_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_backoff |-> $past(CALC_W'(frame_left) < pkt_ts));

    p_health_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_backoff && !$past(health_clr) && ($past(health_cnt) != CNT_MAX))
            |-> (health_cnt == $past(health_cnt) + 1'b1));

    p_health_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (health_cnt == CNT_MAX && !health_clr) |=> (health_cnt == CNT_MAX));

    p_health_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        health_clr |=> (health_cnt == '0));

    p_host_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> !req_ready);

    p_host_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |=> !fetch_en);

    p_one_inflight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> !req_ready);

endmodule

bind tx_prefill_sched txpf_sched_chk #(
    .T_W    (T_W),
    .H_W    (H_W),
    .CALC_W (CALC_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_mode   (host_mode),
    .req_ready   (req_ready),
    .frame_left  (frame_left),
    .pkt_ts      (pkt_ts),
    .health_clr  (health_clr),
    .health_cnt  (health_cnt),
    .fetch_en    (fetch_en),
    .fifo_flush  (fifo_flush),
    .pkt_done    (pkt_done),
    .pkt_defer   (pkt_defer),
    .pkt_backoff (pkt_backoff)
);

// File: tb/test_tx_prefill_sched.sv
module test_tx_prefill_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [10:0] req_len = '0;
    logic        req_ready;
    logic [15:0] cfg_overhead = 16'd20;
    logic [7:0]  cfg_byte_time = 8'd8;
    logic [15:0] cfg_fetch_time = 16'd50;
    logic [7:0]  cfg_burst = 8'd4;
    logic [15:0] frame_left = 16'd1000;
    logic [9:0]  fifo_level = '0;
    logic        fetch_en;
    logic [2:0]  fetch_burst;
    logic        fifo_flush;
    logic        pkt_done;
    logic        pkt_defer;
    logic        pkt_backoff;
    logic        health_clr = 1'b0;
    logic [7:0]  health_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tx_prefill_sched i_tx_prefill_sched (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_mode      (host_mode),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_len        (req_len),
        .req_ready      (req_ready),
        .cfg_overhead   (cfg_overhead),
        .cfg_byte_time  (cfg_byte_time),
        .cfg_fetch_time (cfg_fetch_time),
        .cfg_burst      (cfg_burst),
        .frame_left     (frame_left),
        .fifo_level     (fifo_level),
        .fetch_en       (fetch_en),
        .fetch_burst    (fetch_burst),
        .fifo_flush     (fifo_flush),
        .pkt_done       (pkt_done),
        .pkt_defer      (pkt_defer),
        .pkt_backoff    (pkt_backoff),
        .health_clr     (health_clr),
        .health_cnt     (health_cnt)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Offers one request for a single edge; outputs of that edge are visible on return
    task automatic send_req(input logic [1:0] kind, input logic [10:0] len);
        req_kind  = kind;
        req_len   = len;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", req_ready, 1);
        chk("R1 fetch_en", fetch_en, 0);
        chk("R1 flush", fifo_flush, 0);
        chk("R1 outcomes", {pkt_done, pkt_defer, pkt_backoff}, 0);
        chk("R1 health", health_cnt, 0);
    endtask

    task automatic t_in_pass();
        frame_left = 16'd0;
        send_req(2'b10, 11'd100);
        chk("R2 in done", pkt_done, 1);
        chk("R2 in no fetch", fetch_en, 0);
        chk("R2 in no defer", pkt_defer, 0);
        chk("R2 in health", health_cnt, 0);
        step();
        chk("R2 done one cycle", pkt_done, 0);
        send_req(2'b11, 11'd4);
        chk("R2 code 3 is IN", pkt_done, 1);
        frame_left = 16'd1000;
        step();
    endtask

    // len 16: send-only 148, full budget 198, 4 words
    task automatic t_admit();
        frame_left = 16'd197;
        send_req(2'b00, 11'd16);
        chk("R3 defer below budget", pkt_defer, 1);
        chk("R3 defer no fetch", fetch_en, 0);
        chk("R3 defer health", health_cnt, 0);
        step();
        chk("R3 defer one cycle", pkt_defer, 0);
        frame_left = 16'd198;
        send_req(2'b01, 11'd16);
        chk("R11 admit at exact budget", fetch_en, 1);
        chk("R11 admit no defer", pkt_defer, 0);
        chk("R10 ready low in fill", req_ready, 0);
        fifo_level = 10'd4;
        step();
        chk("R4 setup filled", pkt_done, 1);
        chk("R4 fetch off after fill", fetch_en, 0);
        fifo_level = '0;
        frame_left = 16'd1000;
        step();
    endtask

    // len 13: 4 words needed
    task automatic t_fill();
        send_req(2'b00, 11'd13);
        chk("R3 admit", fetch_en, 1);
        fifo_level = 10'd3;
        step();
        chk("R4 partial fill keeps fetch", fetch_en, 1);
        chk("R4 partial fill no done", pkt_done, 0);
        fifo_level = 10'd4;
        step();
        chk("R4 rounded-up word count done", pkt_done, 1);
        chk("R4 fetch falls", fetch_en, 0);
        chk("R10 ready back", req_ready, 1);
        fifo_level = '0;
        step();
        chk("R4 done one cycle", pkt_done, 0);
    endtask

    task automatic t_backoff();
        logic [7:0] h0;
        h0 = health_cnt;
        send_req(2'b00, 11'd16);
        frame_left = 16'd148;
        step();
        chk("R11 no backoff at exact send time", pkt_backoff, 0);
        chk("R11 still fetching", fetch_en, 1);
        frame_left = 16'd147;
        step();
        chk("R5 backoff", pkt_backoff, 1);
        chk("R5 flush", fifo_flush, 1);
        chk("R5 fetch off", fetch_en, 0);
        chk("R6 health inc", health_cnt, h0 + 8'd1);
        step();
        chk("R5 pulses one cycle", {pkt_backoff, fifo_flush}, 0);
        frame_left = 16'd1000;
    endtask

    task automatic t_priority();
        send_req(2'b00, 11'd16);
        fifo_level = 10'd4;
        frame_left = 16'd100;
        step();
        chk("R5 backoff wins", pkt_backoff, 1);
        chk("R5 no done on backoff", pkt_done, 0);
        fifo_level = '0;
        frame_left = 16'd1000;
        step();
    endtask

    task automatic t_host_drop();
        logic [7:0] h0;
        h0 = health_cnt;
        send_req(2'b00, 11'd16);
        host_mode = 1'b0;
        step();
        chk("R8 flush on host exit", fifo_flush, 1);
        chk("R8 no backoff on host exit", pkt_backoff, 0);
        chk("R8 fetch off", fetch_en, 0);
        chk("R8 health unchanged", health_cnt, h0);
        chk("R8 ready low", req_ready, 0);
        send_req(2'b10, 11'd8);
        chk("R8 request ignored", {pkt_done, pkt_defer, fetch_en}, 0);
        host_mode = 1'b1;
        #1;
        chk("R8 ready back", req_ready, 1);
    endtask

    task automatic t_burst();
        cfg_burst = 8'd0;
        #1;
        chk("R9 zero gives 1", fetch_burst, 1);
        cfg_burst = 8'd3;
        #1;
        chk("R9 pass 3", fetch_burst, 3);
        cfg_burst = 8'd4;
        #1;
        chk("R9 pass 4", fetch_burst, 4);
        cfg_burst = 8'd9;
        #1;
        chk("R9 clamp 9", fetch_burst, 4);
        cfg_burst = 8'd255;
        #1;
        chk("R9 clamp 255", fetch_burst, 4);
        cfg_burst = 8'd4;
    endtask

    task automatic t_clear();
        health_clr = 1'b1;
        step();
        health_clr = 1'b0;
        chk("R7 clear", health_cnt, 0);
        send_req(2'b00, 11'd16);
        send_req(2'b00, 11'd16);
        chk("R7 second request not taken in fill", fetch_en, 1);
        frame_left = 16'd0;
        step();
        chk("R7 count before clear", health_cnt, 1);
        frame_left = 16'd1000;
        send_req(2'b00, 11'd16);
        frame_left = 16'd0;
        health_clr = 1'b1;
        step();
        health_clr = 1'b0;
        chk("R7 backoff with clear", pkt_backoff, 1);
        chk("R7 clear beats inc", health_cnt, 0);
        frame_left = 16'd1000;
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 256; i++) begin
            frame_left = 16'd1000;
            send_req(2'b00, 11'd16);
            frame_left = 16'd0;
            step();
            if (i == 254) chk("R6 reaches max", health_cnt, 255);
        end
        chk("R6 saturated", health_cnt, 255);
        frame_left = 16'd1000;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        t_reset();
        t_in_pass();
        t_admit();
        t_fill();
        t_backoff();
        t_priority();
        t_host_drop();
        t_burst();
        t_clear();
        t_saturate();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule